// File: doc/BRIEF.md
# Sub-LSB Error Table Compensator

This block sits on the sample stream of an L-bit signed converter and removes its static nonlinearity. Every incoming code addresses its own entry in a correction table. The code is first widened by FRAC_W fractional bits, which puts it on a grid FRAC_W bits finer than the converter's own. The signed entry is then added to it, and the sum is clipped to the output range. Each stored correction is meant to move its code to the centre of the code's ideal bin on the finer grid, so the residual error is a fraction of one converter LSB. With FRAC_W = 0 the block is an ordinary error table that corrects to whole LSBs.

The datapath accepts one sample per clock. It has two register stages: a table read, then the add and clip. A write port lets the calibration logic rewrite any entry while the stream runs, so the converter can be relinearized on demand. Reset clears every entry, which makes the block a pure widening stage until it is calibrated.

Top module: `beet_comp`

## Requirements
- R1: During reset and right after it, valid_o is 0 and data_o is 0, and every table entry is zero. So before any write, a sample with code K leaves as K·2^FRAC_W.
- R2: valid_o is valid_i delayed by exactly two clock cycles, and the block accepts a new sample on every cycle.
- R3: For a valid sample with code K, data_o = K·2^FRAC_W + C, where C is the signed CORR_W-bit entry stored at the table address given by the two's-complement bit pattern of K. C is in units of 2^-FRAC_W converter LSB. When no clipping occurs, data_o − K·2^FRAC_W lies in [−2^(CORR_W−1), 2^(CORR_W−1)−1].
- R4: A sum above 2^(CODE_W+FRAC_W−1)−1 is output as that maximum (2047 for the defaults) and does not wrap.
- R5: A sum below −2^(CODE_W+FRAC_W−1) is output as that minimum (−2048 for the defaults) and does not wrap.
- R6: If tbl_we_i writes an entry on the same cycle that a sample with that code enters, the sample uses the old entry. A sample of that code entering on the next cycle uses the new entry.
- R7: A table write changes only the entry at its own address. Samples of every other code are unaffected.
- R8: While valid_o is 0, data_o keeps its last value, whatever code_i carries.
- R9: With FRAC_W = 0 the output is CODE_W bits wide and equals K + C, clipped to the CODE_W-bit signed range, so the correction is in whole LSBs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample valid |
| code_i | input | CODE_W | Signed converter code |
| tbl_we_i | input | 1 | Table write enable |
| tbl_addr_i | input | CODE_W | Code whose entry is written (two's-complement pattern) |
| tbl_data_i | input | CORR_W | Signed correction, units of 2^-FRAC_W LSB |
| valid_o | output | 1 | Output sample valid |
| data_o | output | CODE_W+FRAC_W | Corrected signed sample |

## Verification
The hardest case to reach is a write to an entry on the same cycle that a sample of that code enters the pipeline. The bench drives the write port and a matching sample on one edge, then the same code again on the next edge. It expects the first result to carry the old entry and the second to carry the new one. Clipping at both rails is reached by loading extreme corrections next to the end codes of the range. The whole-LSB case is covered by a second instance built with no fractional bits.

// File: rtl/beet_pkg.sv
package beet_pkg;
  localparam int unsigned CODE_W_DEF = 8;
  localparam int unsigned FRAC_W_DEF = 4;
  localparam int unsigned CORR_W_DEF = 6;
endpackage

// File: rtl/beet_table.sv
module beet_table #(
  parameter int unsigned CODE_W = beet_pkg::CODE_W_DEF,
  parameter int unsigned CORR_W = beet_pkg::CORR_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CODE_W-1:0] waddr_i,
  input  logic [CORR_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [CODE_W-1:0] raddr_i,
  output logic [CORR_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << CODE_W;

  logic [CORR_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  // read sees contents before any same-edge write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/beet_add_sat.sv
module beet_add_sat #(
  parameter int unsigned CODE_W = beet_pkg::CODE_W_DEF,
  parameter int unsigned FRAC_W = beet_pkg::FRAC_W_DEF,
  parameter int unsigned CORR_W = beet_pkg::CORR_W_DEF
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [CODE_W-1:0]        code_i,
  input  logic [CORR_W-1:0]        corr_i,
  output logic                     valid_o,
  output logic [CODE_W+FRAC_W-1:0] data_o
);
  localparam int unsigned OUT_W = CODE_W + FRAC_W;
  localparam int unsigned SUM_W = OUT_W + 1;
  localparam logic [OUT_W-1:0] MAX_V = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] MIN_V = {1'b1, {(OUT_W-1){1'b0}}};

  logic [SUM_W-1:0] code_x, corr_x, sum;
  logic [OUT_W-1:0] sat;

  always_comb begin
    code_x = {{(SUM_W-CODE_W){code_i[CODE_W-1]}}, code_i} << FRAC_W;
    corr_x = {{(SUM_W-CORR_W){corr_i[CORR_W-1]}}, corr_i};
    sum    = code_x + corr_x;
    if (sum[SUM_W-1] != sum[SUM_W-2]) sat = sum[SUM_W-1] ? MIN_V : MAX_V;
    else                              sat = sum[OUT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= sat;
    end
  end
endmodule

// File: rtl/beet_comp.sv
module beet_comp #(
  parameter int unsigned CODE_W = beet_pkg::CODE_W_DEF,
  parameter int unsigned FRAC_W = beet_pkg::FRAC_W_DEF,
  parameter int unsigned CORR_W = beet_pkg::CORR_W_DEF
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [CODE_W-1:0]        code_i,
  input  logic                     tbl_we_i,
  input  logic [CODE_W-1:0]        tbl_addr_i,
  input  logic [CORR_W-1:0]        tbl_data_i,
  output logic                     valid_o,
  output logic [CODE_W+FRAC_W-1:0] data_o
);
  logic              s1_valid_q;
  logic [CODE_W-1:0] s1_code_q;
  logic [CORR_W-1:0] s1_corr;

  beet_table #(.CODE_W(CODE_W), .CORR_W(CORR_W)) u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (tbl_we_i),
    .waddr_i (tbl_addr_i),
    .wdata_i (tbl_data_i),
    .re_i    (valid_i),
    .raddr_i (code_i),
    .rdata_o (s1_corr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q <= 1'b0;
      s1_code_q  <= '0;
    end else begin
      s1_valid_q <= valid_i;
      if (valid_i) s1_code_q <= code_i;
    end
  end

  beet_add_sat #(.CODE_W(CODE_W), .FRAC_W(FRAC_W), .CORR_W(CORR_W)) u_add (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (s1_valid_q),
    .code_i  (s1_code_q),
    .corr_i  (s1_corr),
    .valid_o (valid_o),
    .data_o  (data_o)
  );
endmodule

// File: rtl/beet_comp_chk.sv
module beet_comp_chk #(
  parameter int unsigned CODE_W = beet_pkg::CODE_W_DEF,
  parameter int unsigned FRAC_W = beet_pkg::FRAC_W_DEF,
  parameter int unsigned CORR_W = beet_pkg::CORR_W_DEF
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     valid_i,
  input logic [CODE_W-1:0]        code_i,
  input logic                     valid_o,
  input logic [CODE_W+FRAC_W-1:0] data_o
);
  logic [1:0]        warm_q;
  logic              vld_d1, vld_d2;
  logic [CODE_W-1:0] code_d1, code_d2;
  int                diff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      warm_q  <= '0;
      vld_d1  <= 1'b0;
      vld_d2  <= 1'b0;
      code_d1 <= '0;
      code_d2 <= '0;
    end else begin
      if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
      vld_d1  <= valid_i;
      vld_d2  <= vld_d1;
      code_d1 <= code_i;
      code_d2 <= code_d1;
    end
  end

  always_comb diff = int'($signed(data_o)) - int'($signed(code_d2)) * (2 ** FRAC_W);

  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && data_o == '0));

  // R2
  valid_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2) |-> (valid_o == vld_d2));

  // R3
  corr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2 && valid_o) |->
      (diff >= -(2 ** (CORR_W-1)) && diff <= (2 ** (CORR_W-1)) - 1));

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q != 2'd0 && !valid_o) |-> $stable(data_o));
endmodule

bind beet_comp beet_comp_chk #(.CODE_W(CODE_W), .FRAC_W(FRAC_W), .CORR_W(CORR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .code_i  (code_i),
  .valid_o (valid_o),
  .data_o  (data_o)
);

// File: tb/beet_comp_bench.sv
module beet_comp_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NV = 8;

  localparam int VEC_CODE [NV] = '{3, -1, 127, 126, -128, -127, 64, 100};
  localparam int VEC_CORR [NV] = '{5, -8, 31, 31, -1, -32, -32, 0};
  localparam int VEC_EXP  [NV] = '{53, -24, 2047, 2047, -2048, -2048, 992, 1600};
  localparam string VEC_REQ [NV] = '{"R3", "R3", "R4", "R3", "R5", "R5", "R3", "R3"};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [7:0]  code_i = '0;
  logic        we = 1'b0;
  logic [7:0]  waddr = '0;
  logic [5:0]  wdata = '0;
  logic        valid_o;
  logic [11:0] data_o;

  logic        l_valid_i = 1'b0;
  logic [7:0]  l_code_i = '0;
  logic        l_we = 1'b0;
  logic [7:0]  l_waddr = '0;
  logic [5:0]  l_wdata = '0;
  logic        l_valid_o;
  logic [7:0]  l_data_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  beet_comp u_beet_comp (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .code_i(code_i),
    .tbl_we_i(we), .tbl_addr_i(waddr), .tbl_data_i(wdata),
    .valid_o(valid_o), .data_o(data_o)
  );

  beet_comp #(.CODE_W(8), .FRAC_W(0), .CORR_W(6)) u_lsb (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(l_valid_i), .code_i(l_code_i),
    .tbl_we_i(l_we), .tbl_addr_i(l_waddr), .tbl_data_i(l_wdata),
    .valid_o(l_valid_o), .data_o(l_data_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int code, input int corr);
    @(negedge clk);
    we = 1'b1; waddr = 8'(code); wdata = 6'(corr);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic lwr(input int code, input int corr);
    @(negedge clk);
    l_we = 1'b1; l_waddr = 8'(code); l_wdata = 6'(corr);
    @(negedge clk);
    l_we = 1'b0;
  endtask

  // one sample through the FRAC_W=0 instance
  task automatic lrun(input string req, input int code, input int exp);
    @(negedge clk);
    l_valid_i = 1'b1; l_code_i = 8'(code);
    @(negedge clk);
    l_valid_i = 1'b0;
    @(negedge clk);
    check(req, int'(l_valid_o), 1);
    check(req, int'($signed(l_data_o)), exp);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int held;
    repeat (3) @(negedge clk);
    // R1 values during reset
    check("R1", int'(valid_o), 0);
    check("R1", int'(data_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(valid_o), 0);

    // R1 cleared table: code 5 widened only
    @(negedge clk);
    valid_i = 1'b1; code_i = 8'(5);
    @(negedge clk);
    valid_i = 1'b0;
    check("R2", int'(valid_o), 0);
    @(negedge clk);
    check("R2", int'(valid_o), 1);
    check("R1", int'($signed(data_o)), 80);

    // load vector table
    for (int i = 0; i < NV; i++) wr(VEC_CODE[i], VEC_CORR[i]);

    // back-to-back stream, each result checked two cycles after entry (R2)
    for (int k = 0; k < NV + 2; k++) begin
      @(negedge clk);
      if (k >= 2) begin
        check("R2", int'(valid_o), 1);
        check(VEC_REQ[k-2], int'($signed(data_o)), VEC_EXP[k-2]);
      end
      if (k < NV) begin
        valid_i = 1'b1; code_i = 8'(VEC_CODE[k]);
      end else begin
        valid_i = 1'b0; code_i = 8'(-77);
      end
    end

    // R8 output held while idle
    held = int'($signed(data_o));
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      code_i = 8'(k * 37);
      check("R8", int'(valid_o), 0);
      check("R8", int'($signed(data_o)), held);
    end

    // R6 write and sample of code 10 on the same edge, then again
    @(negedge clk);
    we = 1'b1; waddr = 8'(10); wdata = 6'(7);
    valid_i = 1'b1; code_i = 8'(10);
    @(negedge clk);
    we = 1'b0;
    code_i = 8'(10);
    @(negedge clk);
    code_i = 8'(11);
    check("R6", int'($signed(data_o)), 160);
    @(negedge clk);
    valid_i = 1'b0;
    check("R6", int'($signed(data_o)), 167);
    @(negedge clk);
    // R7 neighbour code 11 untouched
    check("R7", int'($signed(data_o)), 176);

    // R9 whole-LSB instance
    lrun("R9", -5, -5);
    lwr(20, 3);
    lwr(127, 5);
    lwr(-128, -2);
    lrun("R9", 20, 23);
    lrun("R9", 127, 127);
    lrun("R9", -128, -128);

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule